// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two 16-bit two's-complement operands and returns the full 32-bit signed product. Partial products are built with the Baugh-Wooley sign treatment: the cross terms that involve exactly one sign bit are inverted, and two fixed correction bits are injected into the sum. Signed inputs therefore need no sign-extended rows and no negation step. The rows are folded into a carry-save pair by chains of full adders. Registers cut the full-adder array into a few short slices, and a carry-select adder resolves the pair in one stage.

In its default form the block accepts a new operand pair on every clock with a valid flag. Each result emerges a fixed number of cycles later with its own valid flag. There is no stall and no back-pressure. One parameter builds an unpipelined reference variant instead. That variant has no internal registers, uses a ripple-carry final adder, and is kept for comparison.

Top module: `bw_mult`

## Requirements
- R1: `product` equals the exact signed 32-bit product of `op_a` and `op_b`, both read as two's-complement, for any operand values.
- R2: Extreme operands give exact results: (-32768)×(-32768) = 0x40000000, (-32768)×32767 = 0xC0008000, and 32767×32767 = 0x3FFF0001.
- R3: In the default pipelined build, `out_valid` is high in cycle n+5 exactly when `in_valid` was high in cycle n, and low otherwise.
- R4: Operand pairs presented on consecutive cycles each produce their own correct result on consecutive cycles, with no gap and no stall.
- R5: A synchronous active-high `rst` forces `out_valid` low on the next edge. It discards every result still in flight, so none of them emerge after `rst` falls.
- R6: With `PIPELINED` set to 0, the block is purely combinational: `out_valid` follows `in_valid` and `product` is correct in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears valid flags only |
| in_valid | input | 1 | Marks the operand pair on `op_a`/`op_b` as a job |
| op_a | input | OPW (16) | Multiplicand, two's-complement |
| op_b | input | OPW (16) | Multiplier, two's-complement |
| out_valid | output | 1 | Marks `product` as the result of a job |
| product | output | 2*OPW (32) | Signed product |

## Verification
The assertions assume that the operands carry defined values whenever `in_valid` is high. They also assume that `rst` is held for at least one edge before the first job. The comparison against the reference product is made only when the result is valid, so operand values outside a job are never checked. The stimulus drives `in_valid` low with defined operands during reset and between bursts. It draws random operands from a fixed seed and mixes them with the sign-bit extremes, so the inverted cross terms and both correction bits are exercised.

// File: rtl/bw_pkg.sv
package bw_pkg;

    localparam int OP_W_DEF = 16;

    typedef enum logic {
        ADD_RIPPLE = 1'b0,
        ADD_CSEL   = 1'b1
    } add_style_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/bw_array_stage.sv
module bw_array_stage
    import bw_pkg::*;
#(
    parameter int OPW       = OP_W_DEF,
    parameter int FIRST_ROW = 0,
    parameter int NROWS     = 6,
    parameter bit REG       = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [OPW-1:0]   in_a,
    input  logic [OPW-1:0]   in_b,
    input  logic [2*OPW-1:0] in_s,
    input  logic [2*OPW-1:0] in_c,
    output logic             out_vld,
    output logic [OPW-1:0]   out_a,
    output logic [OPW-1:0]   out_b,
    output logic [2*OPW-1:0] out_s,
    output logic [2*OPW-1:0] out_c
);
    localparam int PW = 2 * OPW;

    typedef struct packed {
        logic [PW-1:0] s;
        logic [PW-1:0] c;
    } cs_pair_t;

    function automatic logic [PW-1:0] pp_row(input logic [OPW-1:0] a,
                                             input logic [OPW-1:0] b,
                                             input int j);
        logic [PW-1:0] row;
        logic          bit_v;
        row = '0;
        for (int i = 0; i < OPW; i++) begin
            bit_v = a[i] & b[j];
            if ((i == OPW - 1) != (j == OPW - 1)) bit_v = ~bit_v;
            row[i + j] = bit_v;
        end
        return row;
    endfunction

    function automatic cs_pair_t fa_layer(input cs_pair_t acc, input logic [PW-1:0] z);
        cs_pair_t r;
        r.s = acc.s ^ acc.c ^ z;
        r.c = ((acc.s & acc.c) | (acc.s & z) | (acc.c & z)) << 1;
        return r;
    endfunction

    cs_pair_t nxt;

    always_comb begin
        nxt.s = in_s;
        nxt.c = in_c;
        for (int r = 0; r < NROWS; r++) begin
            if (FIRST_ROW + r < OPW) nxt = fa_layer(nxt, pp_row(in_a, in_b, FIRST_ROW + r));
        end
    end

    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) out_vld <= 1'b0;
                else     out_vld <= in_vld;
            end
            always_ff @(posedge clk) begin
                out_a <= in_a;
                out_b <= in_b;
                out_s <= nxt.s;
                out_c <= nxt.c;
            end
        end else begin : g_comb
            assign out_vld = in_vld;
            assign out_a   = in_a;
            assign out_b   = in_b;
            assign out_s   = nxt.s;
            assign out_c   = nxt.c;
        end
    endgenerate

endmodule

// File: rtl/bw_final_add.sv
module bw_final_add
    import bw_pkg::*;
#(
    parameter int         PW    = 32,
    parameter add_style_e STYLE = ADD_CSEL,
    parameter int         BLK   = 8,
    parameter bit         REG   = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic          out_vld,
    output logic [PW-1:0] sum
);
    localparam int NBLK = PW / BLK;

    logic [PW-1:0] sum_c;

    generate
        if (STYLE == ADD_CSEL) begin : g_csel
            always_comb begin
                logic         cy;
                logic [BLK:0] s0;
                logic [BLK:0] s1;
                cy = 1'b0;
                for (int k = 0; k < NBLK; k++) begin
                    s0 = {1'b0, x[k*BLK +: BLK]} + {1'b0, y[k*BLK +: BLK]};
                    s1 = s0 + 1'b1;
                    sum_c[k*BLK +: BLK] = cy ? s1[BLK-1:0] : s0[BLK-1:0];
                    cy = cy ? s1[BLK] : s0[BLK];
                end
            end
        end else begin : g_ripple
            always_comb begin
                logic cy;
                cy = 1'b0;
                for (int i = 0; i < PW; i++) begin
                    sum_c[i] = x[i] ^ y[i] ^ cy;
                    cy       = (x[i] & y[i]) | (x[i] & cy) | (y[i] & cy);
                end
            end
        end

        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) out_vld <= 1'b0;
                else     out_vld <= in_vld;
            end
            always_ff @(posedge clk) sum <= sum_c;
        end else begin : g_comb
            assign out_vld = in_vld;
            assign sum     = sum_c;
        end
    endgenerate

endmodule

// File: rtl/bw_mult.sv
module bw_mult
    import bw_pkg::*;
#(
    parameter int OPW           = OP_W_DEF,
    parameter int NUM_ARRAY_STG = 3,
    parameter bit PIPELINED     = 1'b1,
    parameter int CSEL_BLK      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic             out_valid,
    output logic [2*OPW-1:0] product
);
    localparam int PW       = 2 * OPW;
    localparam int ROWS_PER = ceil_div(OPW, NUM_ARRAY_STG);
    localparam int LAT      = PIPELINED ? NUM_ARRAY_STG + 2 : 0;
    localparam add_style_e FINAL_STYLE = PIPELINED ? ADD_CSEL : ADD_RIPPLE;

    // Correction bits of the signed array: weights OPW and PW-1.
    localparam logic [PW-1:0] BW_CORR = (PW'(1) << OPW) | (PW'(1) << (PW - 1));

    logic            vld_q [0:NUM_ARRAY_STG];
    logic [OPW-1:0]  a_q   [0:NUM_ARRAY_STG];
    logic [OPW-1:0]  b_q   [0:NUM_ARRAY_STG];
    logic [PW-1:0]   s_q   [0:NUM_ARRAY_STG];
    logic [PW-1:0]   c_q   [0:NUM_ARRAY_STG];

    assign s_q[0] = BW_CORR;
    assign c_q[0] = '0;

    generate
        if (PIPELINED) begin : g_in_reg
            always_ff @(posedge clk) begin
                if (rst) vld_q[0] <= 1'b0;
                else     vld_q[0] <= in_valid;
            end
            always_ff @(posedge clk) begin
                a_q[0] <= op_a;
                b_q[0] <= op_b;
            end
        end else begin : g_in_comb
            assign vld_q[0] = in_valid;
            assign a_q[0]   = op_a;
            assign b_q[0]   = op_b;
        end

        for (genvar k = 0; k < NUM_ARRAY_STG; k++) begin : g_stg
            bw_array_stage #(
                .OPW       (OPW),
                .FIRST_ROW (k * ROWS_PER),
                .NROWS     (ROWS_PER),
                .REG       (PIPELINED)
            ) u_stg (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (vld_q[k]),
                .in_a    (a_q[k]),
                .in_b    (b_q[k]),
                .in_s    (s_q[k]),
                .in_c    (c_q[k]),
                .out_vld (vld_q[k+1]),
                .out_a   (a_q[k+1]),
                .out_b   (b_q[k+1]),
                .out_s   (s_q[k+1]),
                .out_c   (c_q[k+1])
            );
        end
    endgenerate

    bw_final_add #(
        .PW    (PW),
        .STYLE (FINAL_STYLE),
        .BLK   (CSEL_BLK),
        .REG   (PIPELINED)
    ) u_fadd (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (vld_q[NUM_ARRAY_STG]),
        .x       (s_q[NUM_ARRAY_STG]),
        .y       (c_q[NUM_ARRAY_STG]),
        .out_vld (out_valid),
        .sum     (product)
    );

endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
    parameter int OPW = 16,
    parameter int LAT = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OPW-1:0]   op_a,
    input logic [OPW-1:0]   op_b,
    input logic             out_valid,
    input logic [2*OPW-1:0] product
);
    localparam int PW = 2 * OPW;

    logic          v_p   [0:LAT];
    logic          x_p   [0:LAT];
    logic [PW-1:0] p_p   [0:LAT];

    assign v_p[0] = in_valid;
    assign x_p[0] = in_valid && (op_a == {1'b1, {(OPW-1){1'b0}}}) && (op_b == {1'b1, {(OPW-1){1'b0}}});
    assign p_p[0] = PW'($signed(op_a)) * PW'($signed(op_b));

    for (genvar i = 1; i <= LAT; i++) begin : g_pipe
        always_ff @(posedge clk) begin
            if (rst) begin
                v_p[i] <= 1'b0;
                x_p[i] <= 1'b0;
            end else begin
                v_p[i] <= v_p[i-1];
                x_p[i] <= x_p[i-1];
            end
            p_p[i] <= p_p[i-1];
        end
    end

    // R3 R4 R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_p[LAT]);

    // R1
    product_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> product == p_p[LAT]);

    // R2
    min_square_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && x_p[LAT]) |-> product == (PW'(1) << (PW - 2)));

    // R1
    product_known_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(product));

    if (LAT > 0) begin : g_rst
        // R5
        reset_flush_chk: assert property (@(posedge clk)
            rst |=> !out_valid);
    end

endmodule

bind bw_mult bw_mult_chk #(.OPW(OPW), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/bw_mult_tb.sv
module bw_mult_tb;
    localparam int OPW = 16;
    localparam int PW  = 32;
    localparam int LAT = 5;
    localparam int HN  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [OPW-1:0] op_a = '0;
    logic [OPW-1:0] op_b = '0;
    logic          out_valid;
    logic [PW-1:0] product;
    logic          ref_valid;
    logic [PW-1:0] ref_product;

    int checks = 0;
    int errors = 0;
    int idx    = 0;
    logic          hv [0:HN-1];
    logic [PW-1:0] hp [0:HN-1];

    always #5 clk = ~clk;

    bw_mult u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product)
    );

    bw_mult #(.PIPELINED(1'b0)) u_ref (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(ref_valid), .product(ref_product)
    );

    function automatic logic [PW-1:0] smul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        longint sa;
        longint sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return PW'(sa * sb);
    endfunction

    task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: check the output due now, then drive the next inputs
    task automatic step(input logic v, input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                        input string req);
        @(negedge clk);
        if (idx >= LAT) begin
            chk("R3 valid", PW'(out_valid), PW'(hv[idx-LAT]));
            if (hv[idx-LAT]) chk(req, product, hp[idx-LAT]);
        end
        in_valid = v;
        op_a = a;
        op_b = b;
        hv[idx] = v;
        hp[idx] = smul(a, b);
        idx++;
        #1;
        chk("R6 ref valid", PW'(ref_valid), PW'(v));
        if (v) chk("R6 ref product", ref_product, smul(a, b));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < HN; i++) begin hv[i] = 1'b0; hp[i] = '0; end
        // R5: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R5 reset state", PW'(out_valid), '0);
        end
        rst = 1'b0;

        // R2: extremes, back to back
        step(1'b1, 16'h8000, 16'h8000, "R2 min*min");
        step(1'b1, 16'h8000, 16'h7FFF, "R2 min*max");
        step(1'b1, 16'h7FFF, 16'h7FFF, "R2 max*max");
        step(1'b1, 16'hFFFF, 16'hFFFF, "R1 -1*-1");
        step(1'b1, 16'h0000, 16'h8000, "R1 zero");
        step(1'b1, 16'hFFFF, 16'h8000, "R1 -1*min");
        step(1'b0, 16'h1234, 16'h5678, "R3 idle");
        step(1'b1, 16'h0001, 16'hFFFF, "R1 1*-1");

        // R4: continuous random stream
        for (int i = 0; i < 400; i++)
            step(1'b1, OPW'($urandom), OPW'($urandom), "R4 stream");

        // R3: sparse random valid
        for (int i = 0; i < 400; i++)
            step(($urandom % 3) == 0, OPW'($urandom), OPW'($urandom), "R1 sparse");

        // R5: reset in the middle of a burst
        for (int i = 0; i < 6; i++)
            step(1'b1, OPW'($urandom), OPW'($urandom), "R4 burst");
        @(negedge clk);
        chk("R3 valid", PW'(out_valid), PW'(hv[idx-LAT]));
        if (hv[idx-LAT]) chk("R4 burst", product, hp[idx-LAT]);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int k = idx - LAT + 1; k < idx; k++) hv[k] = 1'b0;
        hv[idx] = 1'b0;
        idx++;
        @(negedge clk);
        chk("R5 flush", PW'(out_valid), '0);
        hv[idx] = 1'b0;
        idx++;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R5 no stale result", PW'(out_valid), '0);
            hv[idx] = 1'b0;
            idx++;
        end

        // random with corner operands mixed in
        for (int i = 0; i < 200; i++) begin
            logic [OPW-1:0] a;
            logic [OPW-1:0] b;
            a = (i % 7 == 0) ? 16'h8000 : OPW'($urandom);
            b = (i % 5 == 0) ? 16'h7FFF : OPW'($urandom);
            step(1'b1, a, b, "R1 mixed");
        end
        for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, "R3 drain");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule